// File: doc/BRIEF.md
# Flash Status and Write-Protection Unit

This unit sits behind the command decoder of a serial NOR flash. It keeps the status byte and decides, for every status write, program or erase request, whether that request may start. A granted request starts a self-timed busy period. The busy period's length depends on the kind of operation and is set by parameters. When the busy period ends, the write-enable latch drops. A granted status write also takes effect at that point.

Protection comes from two places. A three-bit protect code shields a region of the array that starts at address zero. The protected size is fixed for each code value. A protect-lock bit, combined with a low level on the write-protect pin, freezes the status byte against writes. The non-volatile bits are loaded from parameters at reset.

A request is decided at the clock edge that samples its strobe. The verdict appears as a one-cycle `grant` or `deny` pulse in the following cycle. At most one strobe is expected per cycle. If several are raised together, the order of precedence is: modify request, then status write, then enable, then disable.

Top module: `flash_guard`

## Requirements
- R1: After reset the status byte reads {INIT_SRP, 0, 0, INIT_BP, 0, 0}, with the write-enable latch and the busy flag both 0.
- R2: The status byte is laid out as bit 7 lock (SRP), bits 6:5 always 0, bits 4:2 protect code BP, bit 1 write-enable latch WEL, and bit 0 busy flag WIP.
- R3: When idle, `wen_stb` sets WEL and `wdis_stb` clears it. The change is visible one cycle after the strobe.
- R4: A modify request or status write that arrives while WEL = 0 is denied and changes nothing.
- R5: A granted request raises WIP in the cycle of the `grant` pulse. WIP then stays 1 for exactly T cycles, where T is T_PAGE, T_SECT, T_BLK32, T_BLK64, T_CHIP or T_SRW depending on the operation. After that, WIP and WEL both read 0.
- R6: A granted status write takes only data bits 7 and 4:2, and they appear when its busy period ends. Status bits 7:2 hold steady while busy.
- R7: When SRP = 1 and `wp_n` = 0, a status write is denied and the status byte, including WEL, is left unchanged.
- R8: The protected range runs from 0 up to a limit L (exclusive), given per BP code: 000 gives L = 0; 001 gives 1FE000h; 010 gives 1FC000h; 011 gives 1F8000h; 100 gives 1F0000h; 101 gives 1E0000h; 110 gives 1C0000h; 111 gives 200000h (the whole array).
- R9: `mod_kind` encodes 0 = page program, 1 = 4 KB sector erase, 2 = 32 KB block erase, 3 = 64 KB block erase. For these kinds, the address is rounded down to its 4 KB, 4 KB, 32 KB or 64 KB boundary. The request is denied when that rounded address is below L.
- R10: Kind 4 (chip erase) is denied whenever BP is not 000. Kinds 5 to 7 are always denied.
- R11: While WIP = 1, every modify request and status write is denied, and `wen_stb` and `wdis_stb` are ignored.
- R12: Every `mod_stb` or `srw_stb` gets exactly one of `grant` or `deny`, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; loads non-volatile bits from parameters |
| wp_n | input | 1 | Write-protect pin, active low |
| wen_stb | input | 1 | Set write-enable latch |
| wdis_stb | input | 1 | Clear write-enable latch |
| srw_stb | input | 1 | Status write request |
| srw_data | input | 8 | Status write data |
| mod_stb | input | 1 | Program or erase request |
| mod_kind | input | 3 | Operation kind (see R9, R10) |
| mod_addr | input | ADDR_W | Target byte address |
| status | output | 8 | Status byte |
| grant | output | 1 | Request accepted (one-cycle pulse) |
| deny | output | 1 | Request refused (one-cycle pulse) |

## Verification
A wrong decision in the protection decode shows up as a `grant` where the scoreboard expects a `deny`, or the reverse, one cycle after the strobe. Requests are therefore placed exactly on each side of every limit that is exercised, and on region boundaries one unit inside them. A busy counter that is off by one changes the number of cycles WIP is seen high, and a lost completion leaves WEL set. Both show up in the status byte within a few cycles. A latch that escapes a busy or locked state shows up as a status byte that changed when it should have stayed the same.

// File: rtl/flash_guard.sv
module flash_guard #(
  parameter int ADDR_W = 21,
  parameter int T_SRW = 5,
  parameter int T_PAGE = 6,
  parameter int T_SECT = 8,
  parameter int T_BLK32 = 10,
  parameter int T_BLK64 = 12,
  parameter int T_CHIP = 16,
  parameter bit INIT_SRP = 1'b0,
  parameter logic [2:0] INIT_BP = 3'b000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              wen_stb,
  input  logic              wdis_stb,
  input  logic              srw_stb,
  input  logic [7:0]        srw_data,
  input  logic              mod_stb,
  input  logic [2:0]        mod_kind,
  input  logic [ADDR_W-1:0] mod_addr,
  output logic [7:0]        status,
  output logic              grant,
  output logic              deny
);
  localparam int SEC_W = 12;
  localparam int B32_W = 15;
  localparam int B64_W = 16;
  localparam int T_A = (T_SRW > T_PAGE) ? T_SRW : T_PAGE;
  localparam int T_B = (T_SECT > T_BLK32) ? T_SECT : T_BLK32;
  localparam int T_C = (T_BLK64 > T_CHIP) ? T_BLK64 : T_CHIP;
  localparam int T_AB = (T_A > T_B) ? T_A : T_B;
  localparam int T_MAX = (T_AB > T_C) ? T_AB : T_C;
  localparam int CNT_W = $clog2(T_MAX + 1);
  localparam logic [7:0] NV_MASK = 8'h9C;
  localparam logic [2:0] K_PAGE = 3'd0, K_SECT = 3'd1, K_B32 = 3'd2, K_B64 = 3'd3, K_CHIP = 3'd4;

  logic [7:0] nv, pend;
  logic wel, wip, pend_is_srw;
  logic [CNT_W-1:0] cnt, dur;
  logic [ADDR_W:0] lim, base;
  logic kind_ok, hit, mod_ok, srw_ok;

  wire [2:0] bp  = nv[4:2];
  wire       hpm = nv[7] & ~wp_n;

  always_comb begin
    lim = '0;
    if (bp == 3'b111)
      lim = (ADDR_W+1)'(1) << ADDR_W;
    else if (bp != 3'b000)
      lim = ((ADDR_W+1)'(1) << ADDR_W) - ((ADDR_W+1)'(1) << (SEC_W + int'(bp)));
  end

  always_comb begin
    base    = {1'b0, mod_addr};
    dur     = CNT_W'(T_PAGE);
    kind_ok = 1'b1;
    case (mod_kind)
      K_PAGE:  base[SEC_W-1:0] = '0;
      K_SECT:  begin base[SEC_W-1:0] = '0; dur = CNT_W'(T_SECT); end
      K_B32:   begin base[B32_W-1:0] = '0; dur = CNT_W'(T_BLK32); end
      K_B64:   begin base[B64_W-1:0] = '0; dur = CNT_W'(T_BLK64); end
      K_CHIP:  dur = CNT_W'(T_CHIP);
      default: kind_ok = 1'b0;
    endcase
  end

  assign hit    = base < lim;
  assign mod_ok = !wip && wel && kind_ok && ((mod_kind == K_CHIP) ? (bp == 3'b000) : !hit);
  assign srw_ok = !wip && wel && !hpm;
  assign status = (nv & NV_MASK) | {6'b0, wel, wip};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv          <= {INIT_SRP, 2'b00, INIT_BP, 2'b00};
      pend        <= '0;
      pend_is_srw <= 1'b0;
      wel         <= 1'b0;
      wip         <= 1'b0;
      cnt         <= '0;
      grant       <= 1'b0;
      deny        <= 1'b0;
    end else begin
      grant <= 1'b0;
      deny  <= 1'b0;
      if (wip) begin
        if (cnt == '0) begin
          wip <= 1'b0;
          wel <= 1'b0;
          if (pend_is_srw) nv <= pend & NV_MASK;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
      if (mod_stb) begin
        if (mod_ok) begin
          grant       <= 1'b1;
          wip         <= 1'b1;
          cnt         <= dur - 1'b1;
          pend_is_srw <= 1'b0;
        end else begin
          deny <= 1'b1;
        end
      end else if (srw_stb) begin
        if (srw_ok) begin
          grant       <= 1'b1;
          wip         <= 1'b1;
          cnt         <= CNT_W'(T_SRW) - 1'b1;
          pend        <= srw_data;
          pend_is_srw <= 1'b1;
        end else begin
          deny <= 1'b1;
        end
      end else if (wen_stb && !wip) begin
        wel <= 1'b1;
      end else if (wdis_stb && !wip) begin
        wel <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wp_n,
  input logic       srw_stb,
  input logic       mod_stb,
  input logic [7:0] status,
  input logic       grant,
  input logic       deny
);
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status[6:5] == 2'b00);

  assert_single_verdict_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && deny));

  assert_verdict_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_stb || srw_stb) |=> (grant || deny));

  assert_grant_needs_wel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> $past(status[1]));

  assert_busy_starts_with_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> grant);

  assert_done_clears_wel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[0]) |-> !status[1]);

  assert_lock_blocks_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (srw_stb && !mod_stb && status[7] && !wp_n) |=> deny);

  assert_busy_rejects_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && (mod_stb || srw_stb)) |=> deny);

  assert_busy_wel_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && $past(status[0])) |-> status[1]);

  assert_nv_steady_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && $past(status[0])) |-> $stable(status[7:2]));
endmodule

bind flash_guard flash_guard_chk u_chk (.*);

// File: tb/tb_flash_guard.sv
`timescale 1ns/1ps
module tb_flash_guard;
  localparam int AW = 21;
  localparam int TP = 6;
  localparam int TC = 16;
  localparam logic [2:0] KP = 3'd0, KS = 3'd1, K32 = 3'd2, K64 = 3'd3, KC = 3'd4;

  logic clk = 1'b0, rst_n = 1'b0, wp_n = 1'b1;
  logic wen_stb = 1'b0, wdis_stb = 1'b0, srw_stb = 1'b0, mod_stb = 1'b0;
  logic [7:0] srw_data = '0;
  logic [2:0] mod_kind = '0;
  logic [AW-1:0] mod_addr = '0;
  logic [7:0] status;
  logic grant, deny;

  int nchk = 0, nfail = 0;
  bit exp_q[$];
  string tag_q[$];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flash_guard #(.ADDR_W(AW), .T_SRW(5), .T_PAGE(TP), .T_SECT(8), .T_BLK32(10),
                .T_BLK64(12), .T_CHIP(TC), .INIT_SRP(1'b0), .INIT_BP(3'b000)) dut (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .wen_stb(wen_stb), .wdis_stb(wdis_stb),
    .srw_stb(srw_stb), .srw_data(srw_data), .mod_stb(mod_stb), .mod_kind(mod_kind),
    .mod_addr(mod_addr), .status(status), .grant(grant), .deny(deny));

  always @(negedge clk) begin
    if (rst_n && (grant || deny)) begin
      nchk++;
      if (exp_q.size() == 0) begin
        nfail++;
        $display("FAIL R12 unexpected verdict: grant=%0b deny=%0b expected none", grant, deny);
      end else begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (grant !== e || deny !== !e) begin
          nfail++;
          $display("FAIL %s verdict: grant=%0b deny=%0b expected grant=%0b", t, grant, deny, e);
        end
      end
    end
  end

  task automatic check_sr(input logic [7:0] e, input string t);
    nchk++;
    if (status !== e) begin
      nfail++;
      $display("FAIL %s status: got %02h expected %02h", t, status, e);
    end
  endtask

  task automatic do_wen();
    @(negedge clk); wen_stb = 1'b1;
    @(negedge clk); wen_stb = 1'b0;
  endtask

  task automatic do_wdis();
    @(negedge clk); wdis_stb = 1'b1;
    @(negedge clk); wdis_stb = 1'b0;
  endtask

  task automatic do_mod(input logic [2:0] k, input logic [AW-1:0] a, input bit g, input string t);
    @(negedge clk);
    mod_kind = k; mod_addr = a; mod_stb = 1'b1;
    exp_q.push_back(g); tag_q.push_back(t);
    @(negedge clk); mod_stb = 1'b0;
  endtask

  task automatic do_srw(input logic [7:0] d, input bit g, input string t);
    @(negedge clk);
    srw_data = d; srw_stb = 1'b1;
    exp_q.push_back(g); tag_q.push_back(t);
    @(negedge clk); srw_stb = 1'b0;
  endtask

  task automatic busy_len(input int e, input string t);
    int n = 0;
    while (status[0] && n < 200) begin
      n++;
      @(negedge clk);
    end
    nchk++;
    if (n != e) begin
      nfail++;
      $display("FAIL %s busy length: got %0d expected %0d", t, n, e);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && status[0]; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    nchk++;
    if (exp_q.size() != 0) begin
      nfail++;
      $display("FAIL R12 missing verdicts: got 0 expected %0d", exp_q.size());
    end
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_sr(8'h00, "R1");

    do_mod(KP, 21'h000000, 1'b0, "R4");
    do_srw(8'h9C, 1'b0, "R4");
    check_sr(8'h00, "R4");

    do_wen();  check_sr(8'h02, "R3");
    do_wdis(); check_sr(8'h00, "R3");

    do_wen();
    do_mod(KP, 21'h000100, 1'b1, "R5");
    check_sr(8'h03, "R5");
    busy_len(TP, "R5");
    check_sr(8'h00, "R5");

    do_wen();
    do_mod(KS, 21'h012345, 1'b1, "R11");
    do_wdis();
    check_sr(8'h03, "R11");
    do_mod(KP, 21'h000000, 1'b0, "R11");
    do_srw(8'h00, 1'b0, "R11");
    wait_idle();
    check_sr(8'h00, "R11");

    do_wen();
    do_srw(8'hFF, 1'b1, "R6");
    check_sr(8'h03, "R6");
    wait_idle();
    check_sr(8'h9C, "R2");

    do_wen();
    do_mod(KP, 21'h1FFFFF, 1'b0, "R8");
    do_mod(KC, 21'h000000, 1'b0, "R10");
    check_sr(8'h9E, "R8");

    wp_n = 1'b0;
    do_srw(8'h00, 1'b0, "R7");
    check_sr(8'h9E, "R7");
    wp_n = 1'b1;
    do_srw(8'h84, 1'b1, "R7");
    wait_idle();
    check_sr(8'h84, "R6");

    do_wen();
    do_mod(KP, 21'h1FDFFF, 1'b0, "R8");
    do_mod(KP, 21'h1FE000, 1'b1, "R8");
    wait_idle();
    check_sr(8'h84, "R8");

    do_wen();
    do_mod(K32, 21'h1FF000, 1'b0, "R9");
    do_mod(K64, 21'h1FFFFF, 1'b0, "R9");
    do_mod(KC, 21'h000000, 1'b0, "R10");
    do_mod(3'd6, 21'h1FF000, 1'b0, "R10");
    do_mod(KS, 21'h1FE123, 1'b1, "R9");
    wait_idle();

    wp_n = 1'b0;
    do_wen();
    do_srw(8'h18, 1'b0, "R7");
    check_sr(8'h86, "R7");
    wp_n = 1'b1;
    do_srw(8'h18, 1'b1, "R8");
    wait_idle();
    check_sr(8'h18, "R8");

    do_wen();
    do_mod(K32, 21'h1BFFFF, 1'b0, "R8");
    do_mod(K64, 21'h1C5000, 1'b1, "R9");
    wait_idle();

    do_wen();
    do_mod(KS, 21'h1BF000, 1'b0, "R8");
    do_srw(8'h00, 1'b1, "R6");
    wait_idle();
    check_sr(8'h00, "R6");

    do_wen();
    do_mod(KC, 21'h000000, 1'b1, "R10");
    busy_len(TC, "R5");
    check_sr(8'h00, "R5");

    repeat (2) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule